// File: doc/BRIEF.md
# Bit-Interleaved Five-Lane Linear Diffusion Layer

This block computes the linear diffusion step of a 320-bit permutation state made of five 64-bit lanes. In the 64-bit view, every lane is XORed with two right-rotated copies of itself. Each lane uses its own pair of rotation amounts. The block never holds a lane as a 64-bit word. Each lane is carried as two 32-bit halves. The even half holds the lane's even-numbered bits and the odd half holds the odd-numbered bits. Every 64-bit rotation is therefore rebuilt as a pair of 32-bit rotations. When the 64-bit amount is odd, the two halves trade places.

The step is linear, so a masked state can be processed one share at a time. The top module holds a parameter number of identical share slices side by side. No slice reads another slice's inputs. The path is purely combinational and contains only fixed rotations and XORs. The nonlinear substitution and the constant injection sit outside this block.

Top module: `bil_diffuse`

## Requirements
- R1: Lane 0, de-interleaved, equals v ^ ror64(v,19) ^ ror64(v,28). Here even half bit i is lane bit 2i and odd half bit i is lane bit 2i+1. Share s lane l sits at bits (s*5+l)*32 of both the even bus and the odd bus.
- R2: Lane 1, in the same 64-bit view, equals v ^ ror64(v,61) ^ ror64(v,39).
- R3: Lane 2, in the same 64-bit view, equals v ^ ror64(v,1) ^ ror64(v,6).
- R4: Lane 3, in the same 64-bit view, equals v ^ ror64(v,10) ^ ror64(v,17).
- R5: Lane 4, in the same 64-bit view, equals v ^ ror64(v,7) ^ ror64(v,41).
- R6: Changing the inputs of one share leaves every output of the other shares unchanged.
- R7: An all-zero state maps to an all-zero state.
- R8: For every lane, the XOR of all 64 output bits equals the XOR of all 64 input bits.
- R9: An all-ones lane maps to an all-ones lane.
- R10: A lane-0 input holding only lane bit 0 gives an output whose set bits are exactly 0, 36 and 45.
- R11: A non-zero input on one lane leaves the outputs of all other lanes at zero when their inputs are zero.
- R12: The outputs follow the inputs within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_even | input | NSHARES*5*32 | Even-bit halves of all lanes of all shares |
| in_odd | input | NSHARES*5*32 | Odd-bit halves of all lanes of all shares |
| out_even | output | NSHARES*5*32 | Even-bit halves after diffusion |
| out_odd | output | NSHARES*5*32 | Odd-bit halves after diffusion |

## Verification
Two kinds of lane transform are active in the same evaluation. Some lanes rotate each half in place because their amounts are even. Other lanes have odd amounts, and there the halves trade places. Dense vectors load every lane of both shares at once, so both kinds run together. Each result is judged against a 64-bit model that knows nothing of the half split. Single-bit sweeps at bits 0, 1, 31, 62 and 63 of each lane make a misplaced swap or an off-by-one half rotation show up as a wrong bit position.

// File: rtl/bil_pkg.sv
package bil_pkg;
   localparam int BIL_LANES  = 5;
   localparam int BIL_LANE_W = 64;

   // first rotation amount of each lane, 64-bit view
   function automatic int bil_rot_a(input int lane);
      case (lane)
         0:       return 19;
         1:       return 61;
         2:       return 1;
         3:       return 10;
         default: return 7;
      endcase
   endfunction

   // second rotation amount of each lane, 64-bit view
   function automatic int bil_rot_b(input int lane);
      case (lane)
         0:       return 28;
         1:       return 39;
         2:       return 6;
         3:       return 17;
         default: return 41;
      endcase
   endfunction

   // v ^ ror(v,a) ^ ror(v,b) == v ^ ror(v ^ ror(v,b-a), a) for a < b
   function automatic int bil_outer(input int lane);
      return (bil_rot_a(lane) < bil_rot_b(lane)) ? bil_rot_a(lane) : bil_rot_b(lane);
   endfunction

   function automatic int bil_inner(input int lane);
      return ((bil_rot_a(lane) < bil_rot_b(lane)) ? bil_rot_b(lane) : bil_rot_a(lane))
             - bil_outer(lane);
   endfunction
endpackage

// File: rtl/bil_ror.sv
// Rotation of an interleaved 64-bit lane, right by AMT, done on its two halves.
module bil_ror #(
   parameter int HALF_W = 32,
   parameter int AMT    = 1
) (
   input  logic [HALF_W-1:0] ev_i,
   input  logic [HALF_W-1:0] od_i,
   output logic [HALF_W-1:0] ev_o,
   output logic [HALF_W-1:0] od_o
);
   localparam int HALF_AMT = AMT / 2;

   function automatic logic [HALF_W-1:0] rot_half(input logic [HALF_W-1:0] x, input int k);
      logic [2*HALF_W-1:0] dbl;
      dbl = {x, x} >> (k % HALF_W);
      return dbl[HALF_W-1:0];
   endfunction

   generate
      if (AMT < 0 || AMT >= 2 * HALF_W) begin : g_bad_amt
         $error("bil_ror: AMT out of range");
      end
      if (AMT % 2 == 0) begin : g_even_amt
         // even amount: each half rotates in place
         assign ev_o = rot_half(ev_i, HALF_AMT);
         assign od_o = rot_half(od_i, HALF_AMT);
      end else begin : g_odd_amt
         // odd amount: halves trade places, the one landing in the odd half moves one step further
         assign ev_o = rot_half(od_i, HALF_AMT);
         assign od_o = rot_half(ev_i, HALF_AMT + 1);
      end
   endgenerate
endmodule

// File: rtl/bil_lane.sv
// One lane: y = x ^ ror(x,RA) ^ ror(x,RB), factored into two interleaved rotations.
module bil_lane #(
   parameter int HALF_W = 32,
   parameter int RA     = 19,
   parameter int RB     = 28
) (
   input  logic [HALF_W-1:0] ev_i,
   input  logic [HALF_W-1:0] od_i,
   output logic [HALF_W-1:0] ev_o,
   output logic [HALF_W-1:0] od_o
);
   localparam int OUTER = (RA < RB) ? RA : RB;
   localparam int INNER = ((RA < RB) ? RB : RA) - OUTER;

   generate
      if (RA == RB) begin : g_bad_pair
         $error("bil_lane: rotation amounts must differ");
      end
   endgenerate

   logic [HALF_W-1:0] r1_ev, r1_od;
   logic [HALF_W-1:0] t_ev,  t_od;
   logic [HALF_W-1:0] r2_ev, r2_od;

   bil_ror #(.HALF_W(HALF_W), .AMT(INNER)) u_inner (
      .ev_i(ev_i), .od_i(od_i), .ev_o(r1_ev), .od_o(r1_od)
   );

   // temporaries come from the pre-update lane only
   assign t_ev = ev_i ^ r1_ev;
   assign t_od = od_i ^ r1_od;

   bil_ror #(.HALF_W(HALF_W), .AMT(OUTER)) u_outer (
      .ev_i(t_ev), .od_i(t_od), .ev_o(r2_ev), .od_o(r2_od)
   );

   assign ev_o = ev_i ^ r2_ev;
   assign od_o = od_i ^ r2_od;
endmodule

// File: rtl/bil_share.sv
// All lanes of one share.
module bil_share
   import bil_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int LANES  = BIL_LANES,
   localparam int SW    = LANES * HALF_W
) (
   input  logic [SW-1:0] ev_i,
   input  logic [SW-1:0] od_i,
   output logic [SW-1:0] ev_o,
   output logic [SW-1:0] od_o
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         bil_lane #(
            .HALF_W(HALF_W),
            .RA    (bil_rot_a(l)),
            .RB    (bil_rot_b(l))
         ) u_lane (
            .ev_i(ev_i[l*HALF_W +: HALF_W]),
            .od_i(od_i[l*HALF_W +: HALF_W]),
            .ev_o(ev_o[l*HALF_W +: HALF_W]),
            .od_o(od_o[l*HALF_W +: HALF_W])
         );
      end
   endgenerate
endmodule

// File: rtl/bil_diffuse.sv
module bil_diffuse
   import bil_pkg::*;
#(
   parameter int NSHARES = 2,
   parameter int LANE_W  = BIL_LANE_W,
   parameter int LANES   = BIL_LANES,
   localparam int HALF_W = LANE_W / 2,
   localparam int SW     = LANES * HALF_W,
   localparam int TW     = NSHARES * SW
) (
   input  logic [TW-1:0] in_even,
   input  logic [TW-1:0] in_odd,
   output logic [TW-1:0] out_even,
   output logic [TW-1:0] out_odd
);
   generate
      if (NSHARES < 1) begin : g_bad_shares
         $error("bil_diffuse: NSHARES must be at least 1");
      end
      if (LANE_W != BIL_LANE_W || LANES != BIL_LANES) begin : g_bad_geom
         $error("bil_diffuse: rotation table fixes five 64-bit lanes");
      end
      for (genvar s = 0; s < NSHARES; s++) begin : g_share
         bil_share #(.HALF_W(HALF_W), .LANES(LANES)) u_share (
            .ev_i(in_even [s*SW +: SW]),
            .od_i(in_odd  [s*SW +: SW]),
            .ev_o(out_even[s*SW +: SW]),
            .od_o(out_odd [s*SW +: SW])
         );
      end
   endgenerate
endmodule

// File: rtl/bil_diffuse_chk.sv
module bil_diffuse_chk
   import bil_pkg::*;
#(
   parameter int NSHARES = 2,
   parameter int LANE_W  = BIL_LANE_W,
   parameter int LANES   = BIL_LANES,
   localparam int HALF_W = LANE_W / 2,
   localparam int TW     = NSHARES * LANES * HALF_W
) (
   input logic [TW-1:0] in_even,
   input logic [TW-1:0] in_odd,
   input logic [TW-1:0] out_even,
   input logic [TW-1:0] out_odd
);
   function automatic logic [LANE_W-1:0] join_lane(input logic [HALF_W-1:0] e,
                                                   input logic [HALF_W-1:0] o);
      logic [LANE_W-1:0] v;
      for (int i = 0; i < HALF_W; i++) begin
         v[2*i]   = e[i];
         v[2*i+1] = o[i];
      end
      return v;
   endfunction

   function automatic logic [LANE_W-1:0] ror_lane(input logic [LANE_W-1:0] v, input int n);
      return (v >> n) | (v << (LANE_W - n));
   endfunction

   always_comb begin
      logic [LANE_W-1:0] vin, vout;
      int base;
      for (int s = 0; s < NSHARES; s++) begin
         for (int l = 0; l < LANES; l++) begin
            base = (s * LANES + l) * HALF_W;
            vin  = join_lane(in_even[base +: HALF_W],  in_odd[base +: HALF_W]);
            vout = join_lane(out_even[base +: HALF_W], out_odd[base +: HALF_W]);
            // R1 R2 R3 R4 R5 R6 R11 R12
            lane_ref_chk: assert (vout == (vin ^ ror_lane(vin, bil_rot_a(l))
                                              ^ ror_lane(vin, bil_rot_b(l))))
               else $error("lane_ref_chk share %0d lane %0d", s, l);
            // R8
            lane_parity_chk: assert ((^vout) == (^vin))
               else $error("lane_parity_chk share %0d lane %0d", s, l);
            // R7
            zero_map_chk: assert (vin != '0 || vout == '0)
               else $error("zero_map_chk share %0d lane %0d", s, l);
            // R9
            ones_map_chk: assert (vin != '1 || vout == '1)
               else $error("ones_map_chk share %0d lane %0d", s, l);
         end
      end
   end
endmodule

bind bil_diffuse bil_diffuse_chk #(
   .NSHARES(NSHARES), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (
   .in_even(in_even), .in_odd(in_odd), .out_even(out_even), .out_odd(out_odd)
);

// File: tb/sim_bil_diffuse.sv
`timescale 1ns/1ps
module sim_bil_diffuse;
   localparam int NS = 2;
   localparam int NL = 5;
   localparam int LW = 64;
   localparam int HW = 32;
   localparam int TW = NS * NL * HW;
   localparam int NV = 6;

   localparam int ROT_A [NL] = '{19, 61, 1, 10, 7};
   localparam int ROT_B [NL] = '{28, 39, 6, 17, 41};
   localparam string TAG [NL] = '{"R1", "R2", "R3", "R4", "R5"};

   localparam logic [LW-1:0] VEC [NV][NL] = '{
      '{64'h0123456789abcdef, 64'hfedcba9876543210, 64'h8000000000000001, 64'h00000000ffffffff, 64'hffffffff00000000},
      '{64'hdeadbeefcafef00d, 64'h5555555555555555, 64'haaaaaaaaaaaaaaaa, 64'h0f0f0f0f0f0f0f0f, 64'h1122334455667788},
      '{64'h7fffffffffffffff, 64'h0000000000000002, 64'h4000000000000000, 64'hc3a5965a3c5a69a5, 64'h0000000100000000},
      '{64'h9e3779b97f4a7c15, 64'hf39cc0605cedc834, 64'h1082276bf3a27251, 64'hd1b54a32d192ed03, 64'h8cb92ba72f3d8dd7},
      '{64'h0000000000000000, 64'hffffffffffffffff, 64'h0000ffff0000ffff, 64'h3333333333333333, 64'h6666666666666666},
      '{64'h243f6a8885a308d3, 64'h13198a2e03707344, 64'ha4093822299f31d0, 64'h082efa98ec4e6c89, 64'h452821e638d01377}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic [TW-1:0] in_e, in_o, out_e, out_o;
   logic [LW-1:0] st [NS][NL];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bil_diffuse #(.NSHARES(NS)) u0 (
      .in_even(in_e), .in_odd(in_o), .out_even(out_e), .out_odd(out_o)
   );

   function automatic logic [LW-1:0] ror64(input logic [LW-1:0] v, input int n);
      return (v >> n) | (v << (LW - n));
   endfunction

   function automatic logic [LW-1:0] model(input logic [LW-1:0] v, input int l);
      return v ^ ror64(v, ROT_A[l]) ^ ror64(v, ROT_B[l]);
   endfunction

   function automatic logic [LW-1:0] got(input int s, input int l);
      logic [LW-1:0] v;
      for (int i = 0; i < HW; i++) begin
         v[2*i]   = out_e[(s*NL+l)*HW + i];
         v[2*i+1] = out_o[(s*NL+l)*HW + i];
      end
      return v;
   endfunction

   task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_state();
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            st[s][l] = '0;
   endtask

   // R12: inputs change after a rising edge and results are sampled at the next falling edge
   task automatic apply();
      @(posedge clk);
      #1;
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            for (int i = 0; i < HW; i++) begin
               in_e[(s*NL+l)*HW + i] = st[s][l][2*i];
               in_o[(s*NL+l)*HW + i] = st[s][l][2*i+1];
            end
      @(negedge clk);
   endtask

   task automatic check_model();
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++) begin
            chk(TAG[l], got(s, l), model(st[s][l], l));
            // R8
            chk("R8", {63'd0, ^got(s, l)}, {63'd0, ^st[s][l]});
         end
   endtask

   initial begin
      logic [LW-1:0] keep [NL];
      rst_n = 1'b0;
      in_e  = '0;
      in_o  = '0;
      clear_state();
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R7: starting state, zero in gives zero out
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            chk("R7", got(s, l), '0);
      rst_n = 1'b1;

      // table walk: both shares loaded with dense vectors at once
      for (int k = 0; k < NV; k++) begin
         for (int l = 0; l < NL; l++) begin
            st[0][l] = VEC[k][l];
            st[1][l] = VEC[(k + 2) % NV][l] ^ {16{4'h5}};
         end
         apply();
         check_model();
      end

      // R9: all ones
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            st[s][l] = '1;
      apply();
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            chk("R9", got(s, l), '1);

      // R7: zero again after a non-zero state
      clear_state();
      apply();
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            chk("R7", got(s, l), '0);

      // R10: lane 0, lane bit 0 only
      st[0][0] = 64'd1;
      apply();
      chk("R10", got(0, 0), (64'd1 << 45) | (64'd1 << 36) | 64'd1);

      // R11: lane 2 of share 1 only
      clear_state();
      st[1][2] = 64'hdeadbeef01234567;
      apply();
      for (int s = 0; s < NS; s++)
         for (int l = 0; l < NL; l++)
            if (!(s == 1 && l == 2)) chk("R11", got(s, l), '0);
      chk("R3", got(1, 2), model(st[1][2], 2));

      // R6: rewrite share 1, share 0 must hold still
      for (int l = 0; l < NL; l++) begin
         st[0][l] = VEC[1][l];
         st[1][l] = VEC[3][l];
      end
      apply();
      for (int l = 0; l < NL; l++) keep[l] = got(0, l);
      for (int l = 0; l < NL; l++) st[1][l] = VEC[4][l] ^ 64'h0f0f00ff;
      apply();
      for (int l = 0; l < NL; l++) chk("R6", got(0, l), keep[l]);

      // R1 to R5 single-bit sweep: odd bits exercise the half swap
      for (int l = 0; l < NL; l++) begin
         for (int b = 0; b < 5; b++) begin
            clear_state();
            st[0][l] = 64'd1 << ((b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 31 : (b == 3) ? 62 : 63);
            apply();
            chk(TAG[l], got(0, l), model(st[0][l], l));
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule